// File: doc/BRIEF.md
# UART Register Front End

This block is the register-facing side of a serial port. A host reaches it through a simple word bus inside a 4 KiB address window. Behind that bus sit a 16-entry receive byte queue, an 11-bit interrupt status set, and storage for the divisor, framing, control, queue-level, infrared-counter and DMA settings. A fixed set of identification bytes lives at the top of the window. Serial bit timing, modem lines and DMA transfers are handled elsewhere. Received bytes arrive on a one-cycle push strobe, and bytes the host writes to the data register leave as a one-cycle valid pulse.

Host accesses pass through a two-state access machine. `ACC_IDLE` waits for a select. A read select moves it to `ACC_READ_RESP`, where the read word is presented with `bus_rvalid` for one cycle. From `ACC_READ_RESP` a further read select keeps it in `ACC_READ_RESP`; anything else returns it to `ACC_IDLE`. A write select completes in the cycle it is accepted and leaves the machine in, or returns it to, `ACC_IDLE`. The single level interrupt output is high whenever any raw status bit is also enabled in the mask.

Top module: `uart_reg_frontend`

## Requirements
- R1: After reset, the flag register (0x18) reads 0x90: bit4 is RX empty and bit7 is TX empty. The mask (0x38), raw status (0x3C) and all storage registers read 0, `irq` is low and `tx_valid` is low.
- R2: A read select returns its word on `bus_rdata` with `bus_rvalid` high in the next cycle. A read of the data register (0x00) pops the receive queue in arrival order and returns 0 when the queue is empty.
- R3: Pushing a byte sets raw status bit4 (receive) and clears flag bit4. A data read that leaves the queue empty clears raw bit4 and sets flag bit4.
- R4: The queue holds 16 bytes, and flag bit6 (RX full) is set while it holds 16. A push into a full queue drops the byte and sets raw bit10 (overrun).
- R5: A write to 0x00 pulses `tx_valid` for exactly one cycle, starting the cycle after the write, with `tx_data` equal to the low 8 bits written. It also sets raw bit5 (transmit), and flag bit7 stays 1.
- R6: The mask at 0x38 keeps 11 bits. Masked status (0x40) reads raw AND mask, and `irq` is high exactly when that value is nonzero.
- R7: Writing 0x44 clears every raw bit written as 1 and leaves the other raw bits unchanged. Reading 0x44 returns 0.
- R8: Storage registers keep only their low bits: 0x20 keeps 8, 0x24 keeps 16, 0x28 keeps 6, 0x2C keeps 8, 0x30 keeps 16, 0x34 keeps 6 and 0x48 keeps 3.
- R9: The identification words 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x11, 0x10, 0x14 and 0x00. The words 0xFF0 to 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1.
- R10: Writes to 0x18, 0x3C and 0x40 change nothing. Offset 0x04 always reads 0, and writes to it change nothing. Unmapped offsets read 0 and ignore writes.
- R11: A status set and a status clear in the same cycle leave the bit set. A push that coincides with the pop of the last byte keeps raw bit4 set and flag bit4 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| rx_push | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a host pop of the last queued byte and a new byte push. The second is a write-one-to-clear of the receive bit and a push that sets it again. The bench drives both sides of each pair on the same falling edge, so the rising edge sees them together. It then reads the raw status, the flags and the remaining queue contents. A correct result keeps the receive bit set, shows the queue as not empty, and returns the pushed byte on the next data read.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
    localparam int ADDR_W = 12;
    localparam int WORD_W = 32;
    localparam int IRQ_W  = 11;

    localparam logic [ADDR_W-1:0] OFS_DATA    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_RSTAT   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_FLAGS   = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_IRCNT   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_DIVINT  = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_DIVFRAC = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_LINE    = 12'h02C;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_LEVEL   = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 12'h03C;
    localparam logic [ADDR_W-1:0] OFS_MSKD    = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_CLR     = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_DMA     = 12'h048;

    localparam int IB_RX      = 4;
    localparam int IB_TX      = 5;
    localparam int IB_OVERRUN = 10;

    localparam int FB_RXE = 4;
    localparam int FB_RXF = 6;
    localparam int FB_TXE = 7;

    typedef enum logic {
        ACC_IDLE,
        ACC_READ_RESP
    } acc_state_t;

    function automatic logic [7:0] ident_byte(input logic [ADDR_W-1:0] a);
        case (a)
            12'hFE0: ident_byte = 8'h11;
            12'hFE4: ident_byte = 8'h10;
            12'hFE8: ident_byte = 8'h14;
            12'hFEC: ident_byte = 8'h00;
            12'hFF0: ident_byte = 8'h0D;
            12'hFF4: ident_byte = 8'hF0;
            12'hFF8: ident_byte = 8'h05;
            12'hFFC: ident_byte = 8'hB1;
            default: ident_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH-1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == FULL_CNT);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dropped = push && full;
    assign head    = empty ? '0 : mem_q[rd_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R4: occupancy never exceeds the depth
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    // R4: a rejected push without a pop leaves the queue full
    a_r4_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic [N-1:0] masked,
    output logic         irq
);
    logic [N-1:0] raw_q, mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_vec) | set_vec;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign raw    = raw_q;
    assign mask   = mask_q;
    assign masked = raw_q & mask_q;
    assign irq    = |masked;

    // R11: a set request always lands, even against a same-cycle clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

    // R7: a clear not contested by a set removes the bit
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/uart_reg_frontend.sv
module uart_reg_frontend
    import uart_reg_pkg::*;
#(
    parameter int RXQ_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int CW = $clog2(RXQ_DEPTH+1);

    acc_state_t state_q, state_d;

    logic rd_req, wr_req;
    assign rd_req = bus_sel && !bus_write;
    assign wr_req = bus_sel &&  bus_write;

    // storage registers
    logic [7:0]  ircnt_q, line_q;
    logic [15:0] divint_q, ctrl_q;
    logic [5:0]  divfrac_q, level_q;
    logic [2:0]  dma_q;

    // receive queue
    logic          q_pop, q_full, q_empty, q_drop;
    logic [7:0]    q_head;
    logic [CW-1:0] q_count;

    assign q_pop = rd_req && (bus_addr == OFS_DATA);

    uart_rx_queue #(.DEPTH(RXQ_DEPTH), .W(8)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_push),
        .din     (rx_byte),
        .pop     (q_pop),
        .head    (q_head),
        .count   (q_count),
        .full    (q_full),
        .empty   (q_empty),
        .dropped (q_drop)
    );

    // interrupt status
    logic [IRQ_W-1:0] set_vec, clr_vec, raw, mask, masked;
    logic             drain, dr_write, clr_write, mask_write;

    assign dr_write   = wr_req && (bus_addr == OFS_DATA);
    assign clr_write  = wr_req && (bus_addr == OFS_CLR);
    assign mask_write = wr_req && (bus_addr == OFS_MASK);
    assign drain      = q_pop && (q_count <= CW'(1));

    always_comb begin
        set_vec = '0;
        set_vec[IB_RX]      = rx_push;
        set_vec[IB_TX]      = dr_write;
        set_vec[IB_OVERRUN] = q_drop;
        clr_vec = clr_write ? bus_wdata[IRQ_W-1:0] : '0;
        clr_vec[IB_RX] = clr_vec[IB_RX] | drain;
    end

    uart_irq_status #(.N(IRQ_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .mask_we    (mask_write),
        .mask_wdata (bus_wdata[IRQ_W-1:0]),
        .raw        (raw),
        .mask       (mask),
        .masked     (masked),
        .irq        (irq)
    );

    // flags
    logic [8:0] flags;
    always_comb begin
        flags = '0;
        flags[FB_RXE] = q_empty;
        flags[FB_RXF] = q_full;
        flags[FB_TXE] = 1'b1;
    end

    // storage register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ircnt_q   <= '0;
            divint_q  <= '0;
            divfrac_q <= '0;
            line_q    <= '0;
            ctrl_q    <= '0;
            level_q   <= '0;
            dma_q     <= '0;
        end else if (wr_req) begin
            case (bus_addr)
                OFS_IRCNT:   ircnt_q   <= bus_wdata[7:0];
                OFS_DIVINT:  divint_q  <= bus_wdata[15:0];
                OFS_DIVFRAC: divfrac_q <= bus_wdata[5:0];
                OFS_LINE:    line_q    <= bus_wdata[7:0];
                OFS_CTRL:    ctrl_q    <= bus_wdata[15:0];
                OFS_LEVEL:   level_q   <= bus_wdata[5:0];
                OFS_DMA:     dma_q     <= bus_wdata[2:0];
                default: ;
            endcase
        end
    end

    // read mux
    logic [WORD_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_DATA:    rd_mux = {24'h0, q_head};
            OFS_RSTAT:   rd_mux = '0;
            OFS_FLAGS:   rd_mux = {23'h0, flags};
            OFS_IRCNT:   rd_mux = {24'h0, ircnt_q};
            OFS_DIVINT:  rd_mux = {16'h0, divint_q};
            OFS_DIVFRAC: rd_mux = {26'h0, divfrac_q};
            OFS_LINE:    rd_mux = {24'h0, line_q};
            OFS_CTRL:    rd_mux = {16'h0, ctrl_q};
            OFS_LEVEL:   rd_mux = {26'h0, level_q};
            OFS_MASK:    rd_mux = {21'h0, mask};
            OFS_RAW:     rd_mux = {21'h0, raw};
            OFS_MSKD:    rd_mux = {21'h0, masked};
            OFS_CLR:     rd_mux = '0;
            OFS_DMA:     rd_mux = {29'h0, dma_q};
            default:     rd_mux = {24'h0, ident_byte(bus_addr)};
        endcase
    end

    // access state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:      state_d = rd_req ? ACC_READ_RESP : ACC_IDLE;
            ACC_READ_RESP: state_d = rd_req ? ACC_READ_RESP : ACC_IDLE;
        endcase
    end

    // access state machine: outputs
    always_comb begin
        unique case (state_q)
            ACC_IDLE:      bus_rvalid = 1'b0;
            ACC_READ_RESP: bus_rvalid = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_mux;
    end

    // transmit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= dr_write;
            if (dr_write) tx_data <= bus_wdata[7:0];
        end
    end

    // R2: every read select is answered in the next cycle
    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    // R5: data write produces a one-cycle strobe carrying the low byte
    a_r5_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dr_write |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

    // R4: push into a full queue raises overrun
    a_r4_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && q_full) |=> raw[IB_OVERRUN]);

    // R3: a push leaves the queue non-empty
    a_r3_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !q_empty);
endmodule

// File: tb/tb_uart_reg_frontend.sv
module tb_uart_reg_frontend;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    uart_reg_frontend dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_write = 0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1; rx_byte = b;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        chk("R1 irq", irq, 0);
        chk("R1 tx_valid", tx_valid, 0);
        expect_rd("R1 flags", 12'h018, 32'h90);
        expect_rd("R1 mask", 12'h038, 0);
        expect_rd("R1 raw", 12'h03C, 0);
        expect_rd("R1 divint", 12'h024, 0);
    endtask

    task automatic t_storage();
        logic [11:0] ofs [7] = '{12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h048};
        logic [31:0] msk [7] = '{32'hFF, 32'hFFFF, 32'h3F, 32'hFF, 32'hFFFF, 32'h3F, 32'h7};
        for (int i = 0; i < 7; i++) bus_wr(ofs[i], 32'hDEADBEEF ^ i);
        for (int i = 0; i < 7; i++) expect_rd("R8 storage width", ofs[i], (32'hDEADBEEF ^ i) & msk[i]);
    endtask

    task automatic t_ident();
        logic [7:0] exp [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) expect_rd("R9 ident", 12'hFE0 + 12'(4*i), {24'h0, exp[i]});
    endtask

    task automatic t_tx();
        @(negedge clk);
        bus_sel = 1; bus_write = 1; bus_addr = 12'h000; bus_wdata = 32'h1A5;
        @(negedge clk);
        bus_sel = 0; bus_write = 0;
        chk("R5 tx_valid pulse", tx_valid, 1);
        chk("R5 tx_data", tx_data, 8'hA5);
        @(negedge clk);
        chk("R5 tx_valid one cycle", tx_valid, 0);
        expect_rd("R5 raw tx bit", 12'h03C, 32'h20);
        expect_rd("R5 flags tx empty", 12'h018, 32'h90);
    endtask

    task automatic t_clear();
        bus_wr(12'h044, 32'h10);
        expect_rd("R7 unrelated bit kept", 12'h03C, 32'h20);
        bus_wr(12'h044, 32'h7FF);
        expect_rd("R7 clear", 12'h03C, 0);
        expect_rd("R7 clear reads zero", 12'h044, 0);
    endtask

    task automatic t_rx_order();
        push(8'h11); push(8'h22); push(8'h33);
        expect_rd("R3 raw rx bit", 12'h03C, 32'h10);
        expect_rd("R3 flags not empty", 12'h018, 32'h80);
        expect_rd("R2 order 1", 12'h000, 32'h11);
        expect_rd("R2 order 2", 12'h000, 32'h22);
        chk("R2 rvalid", bus_rvalid, 1);
        expect_rd("R3 raw kept before last", 12'h03C, 32'h10);
        expect_rd("R2 order 3", 12'h000, 32'h33);
        expect_rd("R3 raw cleared on drain", 12'h03C, 0);
        expect_rd("R3 flags empty again", 12'h018, 32'h90);
        expect_rd("R2 empty read zero", 12'h000, 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        bus_wr(12'h038, 32'hFFFF);
        expect_rd("R6 mask width", 12'h038, 32'h7FF);
        chk("R6 irq idle", irq, 0);
        push(8'h44);
        chk("R6 irq on rx", irq, 1);
        expect_rd("R6 masked", 12'h040, 32'h10);
        bus_wr(12'h038, 32'h20);
        chk("R6 irq masked off", irq, 0);
        expect_rd("R6 masked zero", 12'h040, 0);
        bus_wr(12'h000, 32'h00);
        chk("R6 irq on tx", irq, 1);
        expect_rd("R6 masked tx", 12'h040, 32'h20);
        bus_wr(12'h044, 32'h7FF);
        chk("R7 irq after clear", irq, 0);
        bus_rd(12'h000, d);
        bus_wr(12'h038, 0);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 16; i++) push(8'(8'h80 + i));
        expect_rd("R4 flags full", 12'h018, 32'hC0);
        expect_rd("R4 no overrun yet", 12'h03C, 32'h10);
        push(8'hEE);
        expect_rd("R4 overrun set", 12'h03C, 32'h410);
        for (int i = 0; i < 16; i++) expect_rd("R4 kept bytes", 12'h000, 32'h80 + i);
        expect_rd("R4 dropped byte absent", 12'h000, 0);
        expect_rd("R4 flags after drain", 12'h018, 32'h90);
        bus_wr(12'h044, 32'h7FF);
    endtask

    task automatic t_ignored();
        bus_wr(12'h038, 32'h7FF);
        bus_wr(12'h018, 32'hFFFF);
        bus_wr(12'h03C, 32'hFFFF);
        bus_wr(12'h040, 32'hFFFF);
        expect_rd("R10 raw untouched", 12'h03C, 0);
        expect_rd("R10 flags untouched", 12'h018, 32'h90);
        chk("R10 irq untouched", irq, 0);
        bus_wr(12'h100, 32'h55);
        expect_rd("R10 unmapped read", 12'h100, 0);
        bus_wr(12'h004, 32'hFF);
        expect_rd("R10 offset 4 reads zero", 12'h004, 0);
        expect_rd("R10 storage untouched", 12'h020, 32'hEF);
        bus_wr(12'h038, 0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        push(8'h5A);
        @(negedge clk);
        bus_sel = 1; bus_write = 0; bus_addr = 12'h000;
        rx_push = 1; rx_byte = 8'h6B;
        @(negedge clk);
        bus_sel = 0; rx_push = 0;
        chk("R11 popped old byte", bus_rdata, 32'h5A);
        expect_rd("R11 rx bit kept on push+drain", 12'h03C, 32'h10);
        expect_rd("R11 not empty", 12'h018, 32'h80);
        expect_rd("R11 new byte", 12'h000, 32'h6B);
        expect_rd("R3 drained", 12'h03C, 0);
        @(negedge clk);
        bus_sel = 1; bus_write = 1; bus_addr = 12'h044; bus_wdata = 32'h10;
        rx_push = 1; rx_byte = 8'h7C;
        @(negedge clk);
        bus_sel = 0; bus_write = 0; rx_push = 0;
        expect_rd("R11 set beats clear", 12'h03C, 32'h10);
        bus_rd(12'h000, d);
        chk("R11 pushed byte", d, 32'h7C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_storage();
        t_ident();
        t_tx();
        t_clear();
        t_rx_order();
        t_mask();
        t_overrun();
        t_ignored();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule